// File: doc/BRIEF.md
# Serial Slave Pause (Hold) Controller

This block decides when a serial-bus slave is paused by its active-low pause pin. It runs on the slave's fast system clock. It first passes the serial clock, the chip select, the pause pin and the quad-mode indication through a short synchronizer. It then produces a registered `held` flag. That flag freezes the slave's shift registers, bit counters and decoder, so a paused transfer resumes at exactly the bit where it stopped. A second registered output tells the data-output driver to go high-impedance.

Changes of the pause pin take effect only while the synchronized serial clock is low. An edge that arrives while the clock is high waits for the clock to fall. Pausing needs the chip to be selected and is unavailable in four-line mode. If chip select is released during a pause, the block emits a one-cycle interface-reset request. It also arms a lock that blocks any new pause until chip select and the pause pin have both been seen high. Internal program, erase and status-write cycles are not influenced by this block.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `held`, `dout_hiz`, `iface_rst` and `reentry_blk` are all 0.
- R2: With `cs_n`=0, `quad_en`=0 and `sclk`=0, a fall of `hold_n` sets `held` and `dout_hiz` to 1 within SYNC_STAGES+1 system clocks.
- R3: If `hold_n` falls while `sclk`=1, `held` stays 0 for as long as `sclk` stays high, and becomes 1 after `sclk` goes low.
- R4: While held with `sclk`=0, a rise of `hold_n` clears `held` and `dout_hiz` within SYNC_STAGES+1 system clocks.
- R5: If `hold_n` rises while `sclk`=1, `held` stays 1 until `sclk` goes low, and then clears.
- R6: With `cs_n`=1, a low `hold_n` never sets `held`.
- R7: While `quad_en`=1, `held` stays 0; raising `quad_en` during a pause clears `held` regardless of `sclk`.
- R8: A rise of `cs_n` while held clears `held`, produces exactly one system-clock pulse on `iface_rst`, and sets `reentry_blk`.
- R9: While `reentry_blk`=1, `held` stays 0 even with `cs_n`=0 and `hold_n`=0. `reentry_blk` clears only once `cs_n` and `hold_n` are both seen high, after which a pause can be entered again.
- R10: While held, toggling `sclk` has no effect on `held` or `dout_hiz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bus clock, raw pin level |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Pause pin, active low |
| quad_en | input | 1 | 1 while the slave runs four-line transfers |
| held | output | 1 | Registered pause flag; freezes shift and decode logic |
| dout_hiz | output | 1 | Registered output-enable override; 1 puts data output in high-impedance |
| iface_rst | output | 1 | One-cycle request to reset the slave interface logic |
| reentry_blk | output | 1 | 1 while a new pause is locked out after a reset |

## Verification
The hardest state to reach from the ports is the lockout. It exists only after chip select is released in the middle of a pause, and it is left only through one particular order of pin releases. The stimulus first builds a real pause, then releases chip select and counts the reset pulses cycle by cycle. It then tries to re-enter the pause with the pause pin still low, both with chip select low and with it high. Only after that does it release the pins in the permitted order and confirm that a fresh pause works again. The deferred entry and exit are reached by holding the serial clock high across the pin edge, and by observing over several system clocks that nothing changes before the clock falls.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    // bit positions inside the synchronized pin bundle
    localparam int unsigned PIN_SCLK = 0;
    localparam int unsigned PIN_CS   = 1;
    localparam int unsigned PIN_HOLD = 2;
    localparam int unsigned PIN_QUAD = 3;
    localparam int unsigned PIN_W    = 4;

    // idle pin levels: clock low, deselected, pause released, single mode
    localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0110;

    typedef struct packed {
        logic held;
        logic hiz;
        logic rst_req;
        logic lock;
    } hold_state_t;

    localparam hold_state_t HOLD_STATE_RST = '{held: 1'b0, hiz: 1'b0, rst_req: 1'b0, lock: 1'b0};

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int unsigned    W       = 4,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] src;
        if (s == 0) begin : g_first
            assign src = d;
        end else begin : g_next
            assign src = stg_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[s] <= RST_VAL;
            end else begin
                stg_q[s] <= src;
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_hold_core.sv
module spi_hold_core
    import spi_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_s,
    input  logic        cs_s,
    input  logic        hold_s,
    input  logic        quad_s,
    output hold_state_t state_o
);

    hold_state_t state_d, state_q;

    always_comb begin
        logic allow;
        state_d = state_q;
        allow   = !cs_s && !quad_s && !state_q.lock;

        // pause level follows the pin only while the serial clock is low
        if (cs_s || quad_s) begin
            state_d.held = 1'b0;
        end else if (!sclk_s) begin
            state_d.held = allow && !hold_s;
        end

        state_d.hiz     = state_d.held;
        state_d.rst_req = cs_s && state_q.held;

        if (cs_s && state_q.held) begin
            state_d.lock = 1'b1;
        end else if (cs_s && hold_s) begin
            state_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_STATE_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic hold_n,
    input  logic quad_en,
    output logic held,
    output logic dout_hiz,
    output logic iface_rst,
    output logic reentry_blk
);

    localparam int unsigned STG = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    logic [PIN_W-1:0] pins_raw, pins_s;
    logic             sclk_s, cs_s, hold_s, quad_s;
    hold_state_t      st;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_SCLK] = sclk;
        pins_raw[PIN_CS]   = cs_n;
        pins_raw[PIN_HOLD] = hold_n;
        pins_raw[PIN_QUAD] = quad_en;
    end

    spi_hold_sync #(
        .W       (PIN_W),
        .STAGES  (STG),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    assign sclk_s = pins_s[PIN_SCLK];
    assign cs_s   = pins_s[PIN_CS];
    assign hold_s = pins_s[PIN_HOLD];
    assign quad_s = pins_s[PIN_QUAD];

    spi_hold_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .cs_s    (cs_s),
        .hold_s  (hold_s),
        .quad_s  (quad_s),
        .state_o (st)
    );

    assign held        = st.held;
    assign dout_hiz    = st.hiz;
    assign iface_rst   = st.rst_req;
    assign reentry_blk = st.lock;

endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic held,
    input logic dout_hiz,
    input logic iface_rst,
    input logic reentry_blk,
    input logic sclk_s,
    input logic cs_s,
    input logic hold_s,
    input logic quad_s
);

    // R2
    hold_entry_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(!sclk_s && !cs_s && !hold_s && !quad_s));

    // R10
    hold_stable_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sclk_s) && !$past(cs_s) && !$past(quad_s)) |-> $stable(held));

    // R7
    quad_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(quad_s) |-> !held);

    // R8
    reset_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iface_rst |=> !iface_rst);

    // R8
    reset_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iface_rst |-> ($past(held) && !held && reentry_blk));

    // R9
    lock_blocks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reentry_blk |-> !held);

    // R2
    hiz_tracks_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $rose(dout_hiz));

endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk u_chk (.*);

// File: tb/spi_hold_ctrl_test.sv
module spi_hold_ctrl_test;

    localparam int unsigned SYNC = 2;
    localparam int unsigned SETTLE = SYNC + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic hold_n = 1'b1;
    logic quad_en = 1'b0;
    logic held, dout_hiz, iface_rst, reentry_blk;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spi_hold_ctrl #(.SYNC_STAGES(SYNC)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .hold_n      (hold_n),
        .quad_en     (quad_en),
        .held        (held),
        .dout_hiz    (dout_hiz),
        .iface_rst   (iface_rst),
        .reentry_blk (reentry_blk)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_pins();
        sclk = 1'b0; cs_n = 1'b1; hold_n = 1'b1; quad_en = 1'b0;
        settle(SETTLE);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        sclk = 1'b0; cs_n = 1'b1; hold_n = 1'b1; quad_en = 1'b0;
        settle(4);
        check("R1", "held in reset", int'(held), 0);
        check("R1", "dout_hiz in reset", int'(dout_hiz), 0);
        rst_n = 1'b1;
        settle(SETTLE);
        check("R1", "held after reset", int'(held), 0);
        check("R1", "iface_rst after reset", int'(iface_rst), 0);
        check("R1", "reentry_blk after reset", int'(reentry_blk), 0);
    endtask

    task automatic t_enter_low();
        cs_n = 1'b0;
        settle(SETTLE);
        hold_n = 1'b0;
        settle(SYNC + 2);
        check("R2", "held after fall, clock low", int'(held), 1);
        check("R2", "dout_hiz after fall, clock low", int'(dout_hiz), 1);
        hold_n = 1'b1;
        settle(SYNC + 2);
        check("R4", "held after rise, clock low", int'(held), 0);
        check("R4", "dout_hiz after rise, clock low", int'(dout_hiz), 0);
        idle_pins();
    endtask

    task automatic t_enter_high();
        cs_n = 1'b0;
        sclk = 1'b1;
        settle(SETTLE);
        hold_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            settle(SETTLE);
            check("R3", "held while clock high", int'(held), 0);
        end
        sclk = 1'b0;
        settle(SETTLE);
        check("R3", "held after clock falls", int'(held), 1);
        sclk = 1'b1;
        settle(SETTLE);
        hold_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            settle(SETTLE);
            check("R5", "held while clock high after rise", int'(held), 1);
        end
        sclk = 1'b0;
        settle(SETTLE);
        check("R5", "held after clock falls", int'(held), 0);
        idle_pins();
    endtask

    task automatic t_ignore_clock();
        cs_n = 1'b0;
        settle(SETTLE);
        hold_n = 1'b0;
        settle(SETTLE);
        for (int i = 0; i < 6; i++) begin
            sclk = ~sclk;
            settle(3);
            check("R10", "held during clock toggle", int'(held), 1);
            check("R10", "dout_hiz during clock toggle", int'(dout_hiz), 1);
        end
        hold_n = 1'b1;
        settle(SETTLE);
        check("R10", "held released after toggling", int'(held), 0);
        idle_pins();
    endtask

    task automatic t_deselected();
        cs_n = 1'b1;
        hold_n = 1'b0;
        settle(SETTLE);
        check("R6", "held while deselected", int'(held), 0);
        check("R6", "dout_hiz while deselected", int'(dout_hiz), 0);
        idle_pins();
    endtask

    task automatic t_quad();
        cs_n = 1'b0;
        quad_en = 1'b1;
        settle(SETTLE);
        hold_n = 1'b0;
        settle(SETTLE);
        check("R7", "held in quad mode", int'(held), 0);
        quad_en = 1'b0;
        settle(SETTLE);
        check("R7", "held after leaving quad", int'(held), 1);
        sclk = 1'b1;
        settle(SETTLE);
        quad_en = 1'b1;
        settle(SETTLE);
        check("R7", "held after entering quad, clock high", int'(held), 0);
        idle_pins();
    endtask

    task automatic t_release_cs();
        int pulses;
        cs_n = 1'b0;
        settle(SETTLE);
        hold_n = 1'b0;
        settle(SETTLE);
        check("R8", "held before release", int'(held), 1);
        cs_n = 1'b1;
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (iface_rst) pulses++;
        end
        check("R8", "iface_rst pulse count", pulses, 1);
        check("R8", "held after release", int'(held), 0);
        check("R8", "reentry_blk after release", int'(reentry_blk), 1);
        cs_n = 1'b0;
        settle(SETTLE);
        check("R9", "held while locked, selected", int'(held), 0);
        check("R9", "lock kept while selected", int'(reentry_blk), 1);
        cs_n = 1'b1;
        settle(SETTLE);
        check("R9", "lock kept while pause pin low", int'(reentry_blk), 1);
        hold_n = 1'b1;
        settle(SETTLE);
        check("R9", "lock cleared", int'(reentry_blk), 0);
        cs_n = 1'b0;
        settle(SETTLE);
        hold_n = 1'b0;
        settle(SETTLE);
        check("R9", "pause works again", int'(held), 1);
        idle_pins();
    endtask

    initial begin
        t_reset();
        t_enter_low();
        t_enter_high();
        t_ignore_clock();
        t_deselected();
        t_quad();
        t_release_cs();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule